// File: doc/BRIEF.md
# Daisy-Chain Serial Result Port

This block sends a converter's result word out on a single serial data line. A host that owns the serial clock and a chip-select line reads the word. The block samples the clock, chip select and the upstream data input with its own faster system clock, so the external clock is never used as a clock inside the design. On each *launch* edge of the serial clock it shifts the word out by one bit, most significant bit first. The launch edge is the rising edge or the falling edge, chosen by a pin. The host samples each bit on the opposite edge.

While it shifts out the result, the block also shifts in whatever is on its upstream data input. Several converters can therefore share one data line by wiring each output to the next device's upstream input. A bit presented upstream reaches this block's output exactly as many launch edges later as the word is wide.

A new result arrives from the converter core as a one-cycle pulse with the data word. It loads the port unless a read is half done at that moment. In that case the new result is thrown away, the read in progress carries on with the old word, and a one-cycle error pulse is raised.

Top module: `adc_slave_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `sdout_oe`, `sdout` and `rd_error` are all 0.
- R2: `sdout_oe` is 1 only while the synchronized chip select is low. When the port is released, `sdout` is driven 0.
- R3: On a falling edge of chip select, the stored word is reloaded and its bit DATA_W-1 appears on `sdout`. Each later launch edge moves the output to the next lower bit.
- R4: With `inv_sclk`=0 the launch edge is the rising edge of `sclk_pin`; with `inv_sclk`=1 it is the falling edge. The other edge leaves `sdout` unchanged.
- R5: With `twos_fmt`=1 the top bit of a newly loaded result is inverted. With `twos_fmt`=0 the result is stored unchanged.
- R6: The `sdin_pin` level sampled at launch edge k of a read appears on `sdout` after launch edge k+DATA_W-1. It stays there until edge k+DATA_W. A bit shifted in at edge 1 therefore shows DATA_W launch periods after the read starts.
- R7: A read is in progress while chip select is low and 1 to DATA_W-1 launch edges have been seen since its falling edge. If `conv_done` arrives during a read, the new result is discarded, `rd_error` is 1 for exactly the next cycle, and both the read in progress and later rereads return the old word.
- R8: If `conv_done` arrives when no read is in progress, the result is stored and `rd_error` stays 0. If chip select is already low with no launch edge yet, `sdout` shows the new top bit within 3 cycles.
- R9: Serial clock edges while chip select is high do not move the shift position. The next read starts from bit DATA_W-1.
- R10: Reading again after chip select goes high and then low returns the same stored word from its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pin | input | 1 | External serial clock |
| csn_pin | input | 1 | Active-low chip select |
| sdin_pin | input | 1 | Upstream serial data for chaining |
| inv_sclk | input | 1 | 0: launch on rising edge, 1: launch on falling edge |
| twos_fmt | input | 1 | 1: invert the top bit of the result on load |
| conv_done | input | 1 | One-cycle pulse: new result on conv_data |
| conv_data | input | DATA_W | Conversion result |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | Output enable for sdout |
| rd_error | output | 1 | One-cycle pulse: result discarded during a read |

## Verification
The checker assumes that `conv_done` is never high on two cycles in a row. It also assumes that chip select, once changed, stays put for longer than the synchronizer depth, so an enable rising at the output still sees chip select low at the pin. The stimulus fires each result pulse for one cycle only. It holds chip select for many cycles between changes, and it runs the serial clock at six system cycles per half period, well above the 4x floor. Random words, formats, edge polarities, chain inputs and extra clock counts are mixed with directed error, mid-read load and ignored-edge cases.

// File: rtl/adc_ssp_pkg.sv
package adc_ssp_pkg;
   typedef enum logic {
      LAUNCH_RISE = 1'b0,
      LAUNCH_FALL = 1'b1
   } launch_sel_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ssp_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= {STAGES{RST_VAL[i]}};
         else        ff_q <= {ff_q[STAGES-2:0], d[i]};
      end
      assign q[i] = ff_q[STAGES-1];
   end
endmodule

// File: rtl/ssp_edge.sv
module ssp_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_low,
   input  logic              cs_fall,
   input  logic              launch,
   input  logic              sdin,
   input  logic              twos_fmt,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              msb,
   output logic              rd_err
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

   logic [DATA_W-1:0] held_q;
   logic [DATA_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              err_q;
   logic              busy;
   logic [DATA_W-1:0] fmt_word;

   assign busy     = cs_low && (cnt_q != '0) && (cnt_q < FULL_CNT);
   assign fmt_word = {conv_data[DATA_W-1] ^ twos_fmt, conv_data[DATA_W-2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         sr_q   <= '0;
         cnt_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= conv_done && busy;
         if (conv_done && !busy) begin
            held_q <= fmt_word;
            sr_q   <= fmt_word;
            cnt_q  <= '0;
         end else if (cs_fall) begin
            sr_q  <= held_q;
            cnt_q <= '0;
         end else if (launch && cs_low) begin
            sr_q <= {sr_q[DATA_W-2:0], sdin};
            if (cnt_q < FULL_CNT) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign msb    = sr_q[DATA_W-1];
   assign rd_err = err_q;
endmodule

// File: rtl/adc_slave_port.sv
module adc_slave_port
   import adc_ssp_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_pin,
   input  logic              csn_pin,
   input  logic              sdin_pin,
   input  logic              inv_sclk,
   input  logic              twos_fmt,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              sdout,
   output logic              sdout_oe,
   output logic              rd_error
);
   if (DATA_W < 2) begin : g_bad_width
      $error("adc_slave_port: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("adc_slave_port: SYNC_STAGES must be at least 2");
   end

   localparam int N_SYNC = 3;

   logic [N_SYNC-1:0] pins_s;
   logic sclk_s, csn_s, sdin_s;
   logic sclk_rise, sclk_fall, cs_rise_unused_n, cs_fall;
   logic launch;
   logic sr_msb;
   launch_sel_t sel;

   ssp_sync #(
      .WIDTH   (N_SYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sdin_pin, csn_pin, sclk_pin}),
      .q     (pins_s)
   );

   assign sclk_s = pins_s[0];
   assign csn_s  = pins_s[1];
   assign sdin_s = pins_s[2];

   ssp_edge #(.RST_VAL(1'b0)) u_sclk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sclk_s),
      .rise  (sclk_rise),
      .fall  (sclk_fall)
   );

   ssp_edge #(.RST_VAL(1'b0)) u_cs_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (~csn_s),
      .rise  (cs_fall),
      .fall  (cs_rise_unused_n)
   );

   assign sel    = inv_sclk ? LAUNCH_FALL : LAUNCH_RISE;
   assign launch = (sel == LAUNCH_FALL) ? sclk_fall : sclk_rise;

   ssp_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_low    (~csn_s),
      .cs_fall   (cs_fall & ~cs_rise_unused_n),
      .launch    (launch),
      .sdin      (sdin_s),
      .twos_fmt  (twos_fmt),
      .conv_done (conv_done),
      .conv_data (conv_data),
      .msb       (sr_msb),
      .rd_err    (rd_error)
   );

   assign sdout_oe = ~csn_s;
   assign sdout    = sdout_oe & sr_msb;
endmodule

// File: rtl/adc_slave_port_chk.sv
module adc_slave_port_chk (
   input logic clk,
   input logic rst_n,
   input logic csn_pin,
   input logic conv_done,
   input logic sdout_oe,
   input logic rd_error
);
   // R7
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_error |-> $past(conv_done));

   // R7
   err_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_error |-> $past(sdout_oe));

   // R2
   oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdout_oe) |-> !csn_pin);

   // R8
   conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !conv_done);
endmodule

bind adc_slave_port adc_slave_port_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .csn_pin   (csn_pin),
   .conv_done (conv_done),
   .sdout_oe  (sdout_oe),
   .rd_error  (rd_error)
);

// File: tb/adc_slave_port_tb_top.sv
module adc_slave_port_tb_top;
   localparam int W    = 18;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_pin = 1'b0, csn_pin = 1'b1, sdin_pin = 1'b0;
   logic inv_sclk = 1'b0, twos_fmt = 1'b0, conv_done = 1'b0;
   logic [W-1:0] conv_data = '0;
   logic sdout, sdout_oe, rd_error;

   int total = 0;
   int bad = 0;
   int err_seen = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adc_slave_port #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .csn_pin(csn_pin),
      .sdin_pin(sdin_pin), .inv_sclk(inv_sclk), .twos_fmt(twos_fmt),
      .conv_done(conv_done), .conv_data(conv_data),
      .sdout(sdout), .sdout_oe(sdout_oe), .rd_error(rd_error)
   );

   always @(posedge clk) if (rst_n && rd_error) err_seen++;

   function automatic logic [W-1:0] fmt(input logic [W-1:0] w, input logic t);
      return {w[W-1] ^ t, w[W-2:0]};
   endfunction

   task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [W-1:0] w, input logic t);
      @(negedge clk);
      conv_data = w; twos_fmt = t; conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      wait_n(2);
   endtask

   task automatic cs_low;
      sclk_pin = inv_sclk;
      wait_n(HALF);
      csn_pin = 1'b0;
      wait_n(HALF + 2);
   endtask

   task automatic cs_high;
      csn_pin = 1'b1;
      wait_n(HALF);
      chk(sdout_oe == 1'b0 && sdout == 1'b0, "R2 release", {sdout_oe, sdout}, 0);
   endtask

   // one launch + trailing edge; returns bit seen after launch
   task automatic clock_edge(input logic din, output logic seen);
      logic after_trail;
      sdin_pin = din;
      wait_n(1);
      sclk_pin = ~inv_sclk;
      wait_n(HALF);
      seen = sdout;
      sclk_pin = inv_sclk;
      wait_n(HALF);
      after_trail = sdout;
      chk(after_trail == seen, "R4 trailing edge no effect", after_trail, seen);
   endtask

   // full read of word w with n launch edges, chain pattern pat
   task automatic read_word(input logic [W-1:0] w, input int n, input logic [63:0] pat, input string rq);
      logic seen, exp;
      cs_low();
      chk(sdout_oe == 1'b1, "R2 enable", sdout_oe, 1);
      chk(sdout == w[W-1], {rq, " R3 first bit"}, sdout, w[W-1]);
      for (int k = 1; k <= n; k++) begin
         clock_edge(pat[k], seen);
         exp = (k < W) ? w[W-1-k] : pat[k-W+1];
         chk(seen == exp, (k < W) ? {rq, " R3 bit"} : {rq, " R6 chain"}, seen, exp);
      end
      cs_high();
   endtask

   initial begin
      logic [W-1:0] wa, wb, wc;
      logic seen;
      int e0;
      void'($urandom(32'd4242));
      wait_n(3);
      // R1 reset state
      chk(sdout_oe == 0 && sdout == 0 && rd_error == 0, "R1 in reset", {sdout_oe, sdout, rd_error}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sdout_oe == 0 && sdout == 0 && rd_error == 0, "R1 after reset", {sdout_oe, sdout, rd_error}, 0);

      // R5 format on a fixed word
      inv_sclk = 1'b0;
      load(18'h20001, 1'b1);
      read_word(fmt(18'h20001, 1'b1), W - 1, 64'd0, "R5 twos");
      load(18'h20001, 1'b0);
      read_word(18'h20001, W - 1, 64'd0, "R5 straight");

      // R4 falling-edge launch
      inv_sclk = 1'b1;
      load(18'h2A5C3, 1'b0);
      read_word(18'h2A5C3, W + 4, 64'h0000_0000_0005_A000, "R4 fall");

      // R9 edges while deselected, then R10 reread
      for (int i = 0; i < 5; i++) begin
         sclk_pin = ~sclk_pin;
         wait_n(HALF);
      end
      read_word(18'h2A5C3, W - 1, 64'd0, "R9 R10 reread");

      // R7 error mid-read
      inv_sclk = 1'b0;
      wa = 18'h1F0F0; wb = 18'h0ABCD;
      load(wa, 1'b0);
      cs_low();
      for (int k = 1; k <= 5; k++) clock_edge(1'b0, seen);
      e0 = err_seen;
      load(wb, 1'b0);
      wait_n(2);
      chk(err_seen - e0 == 1, "R7 one error pulse", err_seen - e0, 1);
      for (int k = 6; k < W; k++) begin
         clock_edge(1'b0, seen);
         chk(seen == wa[W-1-k], "R7 old word continues", seen, wa[W-1-k]);
      end
      cs_high();
      read_word(wa, W - 1, 64'd0, "R7 discarded");

      // R8 load while selected, no edges yet
      wc = 18'h3C00F;
      cs_low();
      e0 = err_seen;
      chk(sdout == wa[W-1], "R8 before load", sdout, wa[W-1]);
      @(negedge clk);
      conv_data = wc; twos_fmt = 1'b0; conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      wait_n(2);
      chk(sdout == wc[W-1], "R8 new top bit", sdout, wc[W-1]);
      chk(err_seen == e0, "R8 no error", err_seen - e0, 0);
      for (int k = 1; k < W; k++) begin
         clock_edge(1'b0, seen);
         chk(seen == wc[W-1-k], "R8 new word", seen, wc[W-1-k]);
      end
      cs_high();
      // R8 load while deselected after an abandoned read
      e0 = err_seen;
      load(wb, 1'b0);
      chk(err_seen == e0, "R8 idle load no error", err_seen - e0, 0);
      read_word(wb, W - 1, 64'd0, "R8 idle load");

      // random mix
      for (int it = 0; it < 20; it++) begin
         logic [W-1:0] w;
         logic t;
         logic [63:0] pat;
         int extra;
         w = W'($urandom);
         t = 1'($urandom);
         inv_sclk = 1'($urandom);
         pat = {$urandom, $urandom};
         extra = $urandom % 11;
         load(w, t);
         read_word(fmt(w, t), W - 1 + extra, pat, "R3 R6 random");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule